// File: doc/BRIEF.md
# Programmable Logic Output Macrocell Bank

This block is the output stage of a small programmable logic device. It holds a row of identical macrocells, ten by default. All cells share one clock, one asynchronous clear and one synchronous preset. The logic array outside the block gives each cell a sum term and an enable product term. Each cell also receives two static configuration bits: one picks registered or combinatorial operation, the other picks inverting or non-inverting output.

Each cell produces two things:
- The data and enable for its pin driver.
- A feedback bit that goes back into the array.

When a cell is in registered mode, the feedback is the register's true output, whatever the enable is doing. When a cell is in combinatorial mode, the feedback is the level on the pin. While the cell drives the pin, that level is its own output. While the enable is low, the driver is in high impedance and the level is whatever is applied from outside. This lets the pin serve as an extra array input.

Top module: `omc_bank`

## Requirements
- R1: With `cfg_reg[i]`=0 (combinatorial), `pin_data[i]` equals `sum_term[i]` XOR `cfg_inv[i]` in the same cycle, without waiting for a clock edge. `cfg_inv` bit 1 means inverting.
- R2: With `cfg_reg[i]`=1 (registered), the cell register captures `sum_term[i]` on each rising edge of `clk`, and `pin_data[i]` equals the register value XOR `cfg_inv[i]`.
- R3: `pin_oe[i]` follows `oe_term[i]`. While it is 0 the driver is treated as high impedance, and the pin level is `pin_in[i]`.
- R4: In registered mode, `feedback[i]` is the register value before polarity, regardless of `oe_term[i]` and `pin_in[i]`.
- R5: In combinatorial mode, `feedback[i]` is the pin level. That is `pin_data[i]` when `oe_term[i]`=1, and `pin_in[i]` when `oe_term[i]`=0.
- R6: `arst`=1 clears every cell register at once, with no clock edge needed. The registers stay cleared across clock edges for as long as `arst` is held, and this is also the power-up state.
- R7: `preset`=1 sets every cell register to 1 at the next rising edge of `clk`, and not before.
- R8: When `arst` and `preset` are both 1, the registers stay cleared.
- R9: Each cell's mode and polarity are independent. Mixed configurations across the row give each cell its own behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared register clock, rising edge |
| arst | input | 1 | Asynchronous clear of all registers, active high |
| preset | input | 1 | Synchronous set of all registers, active high |
| sum_term | input | N_CELLS | Sum term per cell from the array |
| oe_term | input | N_CELLS | Output enable product term per cell |
| cfg_reg | input | N_CELLS | Mode per cell: 1 registered, 0 combinatorial |
| cfg_inv | input | N_CELLS | Polarity per cell: 1 inverting, 0 non-inverting |
| pin_in | input | N_CELLS | Level applied to each pin from outside |
| pin_data | output | N_CELLS | Value each pin driver presents |
| pin_oe | output | N_CELLS | Driver enable per pin; 0 means high impedance |
| feedback | output | N_CELLS | Feedback bit per cell back into the array |

## Verification
The hardest situation to reach is a registered cell whose enable is off while the outside level on its pin differs from the register. There the feedback must ignore the pin, while a combinatorial neighbour in the same row must take its feedback from the pin. The stimulus table builds mixed rows, with alternating modes, polarities and enables, and with pin levels chosen opposite to the register contents. The reset and preset corners are driven between clock edges, so that the clear is seen before any edge and the preset is seen only after one.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef struct packed {
        logic registered;
        logic invert;
    } cell_cfg_t;

    typedef struct packed {
        logic data;
        logic oe;
    } pin_drv_t;

    function automatic logic apply_polarity(logic v, logic inv);
        return v ^ inv;
    endfunction

    function automatic logic resolve_pin(pin_drv_t drv, logic ext);
        return drv.oe ? drv.data : ext;
    endfunction

endpackage

// File: rtl/omc_reg.sv
module omc_reg (
    input  logic clk,
    input  logic arst,
    input  logic preset,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            q <= 1'b0;
        else if (preset)
            q <= 1'b1;
        else
            q <= d;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (arst)
        !preset |=> q == $past(d));

    p_preset_sets_r7: assert property (@(posedge clk) disable iff (arst)
        preset |=> q == 1'b1);

endmodule

// File: rtl/omc_drive.sv
module omc_drive
    import omc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      q,
    input  logic      oe_term,
    output pin_drv_t  drv
);

    logic src;

    always_comb begin
        src      = cfg.registered ? q : sum;
        drv.data = apply_polarity(src, cfg.invert);
        drv.oe   = oe_term;
    end

endmodule

// File: rtl/omc_fbsel.sv
module omc_fbsel
    import omc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  pin_drv_t  drv,
    input  logic      pin_in,
    output logic      fb
);

    logic pin_level;

    always_comb begin
        pin_level = resolve_pin(drv, pin_in);
        fb        = cfg.registered ? q : pin_level;
    end

endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
(
    input  logic      clk,
    input  logic      arst,
    input  logic      preset,
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      oe_term,
    input  logic      pin_in,
    output pin_drv_t  drv,
    output logic      fb
);

    logic q;

    omc_reg u_reg (
        .clk    (clk),
        .arst   (arst),
        .preset (preset),
        .d      (sum),
        .q      (q)
    );

    omc_drive u_drive (
        .cfg     (cfg),
        .sum     (sum),
        .q       (q),
        .oe_term (oe_term),
        .drv     (drv)
    );

    omc_fbsel u_fbsel (
        .cfg    (cfg),
        .q      (q),
        .drv    (drv),
        .pin_in (pin_in),
        .fb     (fb)
    );

    p_comb_pin_r1: assert property (@(posedge clk) disable iff (arst)
        !cfg.registered |-> drv.data == (sum ^ cfg.invert));

    p_reg_pin_r2: assert property (@(posedge clk) disable iff (arst)
        cfg.registered |-> drv.data == (fb ^ cfg.invert));

    p_reg_fb_r4: assert property (@(posedge clk) disable iff (arst)
        cfg.registered |-> fb == q);

    p_comb_fb_r5: assert property (@(posedge clk) disable iff (arst)
        (!cfg.registered && !oe_term) |-> fb == pin_in);

endmodule

// File: rtl/omc_bank.sv
module omc_bank
    import omc_pkg::*;
#(
    parameter int N_CELLS = 10
) (
    input  logic               clk,
    input  logic               arst,
    input  logic               preset,
    input  logic [N_CELLS-1:0] sum_term,
    input  logic [N_CELLS-1:0] oe_term,
    input  logic [N_CELLS-1:0] cfg_reg,
    input  logic [N_CELLS-1:0] cfg_inv,
    input  logic [N_CELLS-1:0] pin_in,
    output logic [N_CELLS-1:0] pin_data,
    output logic [N_CELLS-1:0] pin_oe,
    output logic [N_CELLS-1:0] feedback
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cfg;
        pin_drv_t  drv;

        assign cfg.registered = cfg_reg[i];
        assign cfg.invert     = cfg_inv[i];

        omc_cell u_cell (
            .clk     (clk),
            .arst    (arst),
            .preset  (preset),
            .cfg     (cfg),
            .sum     (sum_term[i]),
            .oe_term (oe_term[i]),
            .pin_in  (pin_in[i]),
            .drv     (drv),
            .fb      (feedback[i])
        );

        assign pin_data[i] = drv.data;
        assign pin_oe[i]   = drv.oe;

        p_oe_track_r3: assert property (@(posedge clk) disable iff (arst)
            pin_oe[i] == oe_term[i]);
    end

endmodule

// File: tb/test_omc_bank.sv
module test_omc_bank;

    localparam int N = 10;

    typedef struct packed {
        logic [N-1:0] mreg;
        logic [N-1:0] minv;
        logic [N-1:0] oe;
        logic [N-1:0] sum;
        logic [N-1:0] pin;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h000, 10'h000, 10'h3FF, 10'h2A5, 10'h000},
        '{10'h000, 10'h3FF, 10'h3FF, 10'h2A5, 10'h3FF},
        '{10'h000, 10'h155, 10'h000, 10'h0F0, 10'h33C},
        '{10'h3FF, 10'h000, 10'h3FF, 10'h1C7, 10'h000},
        '{10'h3FF, 10'h2AA, 10'h000, 10'h238, 10'h3FF},
        '{10'h155, 10'h0F0, 10'h333, 10'h3C3, 10'h2AA},
        '{10'h2AA, 10'h30F, 10'h0CC, 10'h11E, 10'h155},
        '{10'h155, 10'h3FF, 10'h000, 10'h000, 10'h3FF}
    };

    logic         clk = 1'b0;
    logic         arst = 1'b1;
    logic         preset = 1'b0;
    logic [N-1:0] sum_term = '0, oe_term = '0, cfg_reg = '0, cfg_inv = '0, pin_in = '0;
    logic [N-1:0] pin_data, pin_oe, feedback;
    logic [N-1:0] mq = '0;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    omc_bank #(.N_CELLS(N)) i_omc_bank (
        .clk(clk), .arst(arst), .preset(preset),
        .sum_term(sum_term), .oe_term(oe_term), .cfg_reg(cfg_reg),
        .cfg_inv(cfg_inv), .pin_in(pin_in),
        .pin_data(pin_data), .pin_oe(pin_oe), .feedback(feedback)
    );

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_data();
        return ((cfg_reg & mq) | (~cfg_reg & sum_term)) ^ cfg_inv;
    endfunction

    function automatic logic [N-1:0] exp_fb();
        logic [N-1:0] lvl;
        lvl = (oe_term & exp_data()) | (~oe_term & pin_in);
        return (cfg_reg & mq) | (~cfg_reg & lvl);
    endfunction

    task automatic check_all(string req);
        chk({req, " pin_data"}, pin_data, exp_data());
        chk({req, " pin_oe R3"}, pin_oe, oe_term);
        chk({req, " feedback"}, feedback, exp_fb());
    endtask

    task automatic clock_edge();
        @(posedge clk);
        if (arst) mq = '0;
        else if (preset) mq = '1;
        else mq = sum_term;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Reset state (R6)
        cfg_reg = '1;
        @(negedge clk); #1;
        chk("R6 reset state", feedback, '0);
        clock_edge();
        chk("R6 held across edge", feedback, '0);
        arst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 R9
        for (int k = 0; k < 8; k++) begin
            cfg_reg  = VECS[k].mreg;
            cfg_inv  = VECS[k].minv;
            oe_term  = VECS[k].oe;
            sum_term = VECS[k].sum;
            pin_in   = VECS[k].pin;
            #1;
            check_all("R1/R5/R9 pre-edge");
            clock_edge();
            check_all("R2/R4/R9 post-edge");
            pin_in = ~pin_in;
            #1;
            check_all("R4/R5 pin flip");
        end

        // Preset not before edge, then sets (R7)
        cfg_reg = '1; cfg_inv = '0; oe_term = '0; sum_term = '0; pin_in = '1;
        clock_edge();
        chk("R7 cleared before preset", feedback, '0);
        preset = 1'b1;
        #1;
        chk("R7 no set before edge", feedback, '0);
        clock_edge();
        chk("R7 set after edge", feedback, '1);
        cfg_inv = 10'h0FF;
        #1;
        chk("R2 inverted preset value", pin_data, 10'h300);

        // Async clear mid-cycle with preset active (R6, R8)
        #1 arst = 1'b1;
        #1;
        chk("R6 async clear no edge", feedback, '0);
        mq = '0;
        clock_edge();
        chk("R8 reset beats preset", feedback, '0);
        clock_edge();
        chk("R8 still clear", pin_data, 10'h0FF);
        preset = 1'b0;
        arst = 1'b0;
        sum_term = 10'h1A5;
        clock_edge();
        chk("R2 capture after release", feedback, 10'h1A5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule